// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block is a single-master I2C controller that carries out one complete register transaction per request. The requester supplies a 7-bit target address, an 8-bit register index, a direction flag, and either one byte to write or a count of bytes to read, and then pulses `go`. For a write, the block sends a START, the address byte with the direction bit cleared, the register index and the data byte, and then a STOP. For a read, it first writes the register index in the same way. It then issues a repeated START with no STOP in between, sends the address byte again with the direction bit set, and clocks in the requested number of bytes.

SCL is driven push-pull. SDA is open-drain: `sda_oe` high pulls the line low. The resolved line level comes back on `sda_in`. A quarter-period tick from a parameterised divider paces every bus phase. Each received byte is presented with a one-cycle `rd_valid` strobe. If the target does not acknowledge within a bounded wait, the block closes the bus with a STOP, ends the transaction and raises `err`.

Top module: `i2c_regseq`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl` is 1, `sda_oe` is 0, `done` is 0, and `err` is 0 until a transaction has failed.
- R2: The first byte after every START or repeated START is the 7-bit address in bits 7..1, with the direction in bit 0 (0 = write, 1 = read). Address 0x68 therefore gives 0xD0 for a write and 0xD1 for a read.
- R3: A write request (`rd_req`=0) produces exactly one START, then address+write, register index and data byte, each acknowledged, then exactly one STOP. The target's register then holds `wr_data`.
- R4: A read request (`rd_req`=1) produces exactly two STARTs and one STOP: address+write and the register index, a repeated START with no STOP before it, then address+read.
- R5: A read delivers exactly `rd_len` bytes (a value of 0 is handled as 1), most significant bit first. Each byte appears on `rd_data` together with a one-cycle `rd_valid` pulse while `busy` is high.
- R6: During a read, the master drives SDA low (ACK) in the ninth bit of every received byte except the last, and leaves SDA released (NACK) after the last byte.
- R7: In the ninth bit of each byte the master sends, SDA is released and a low level means acknowledge. If the line stays high for ACK_WAIT quarter periods after the first high quarter of SCL, the block ends the transaction with a STOP, delivers no further bytes and sets `err`. `err` holds its value while idle and is cleared by the next `go`.
- R8: An acknowledge that arrives late during SCL high, but inside the ACK_WAIT window, is accepted and the transaction completes with `err`=0.
- R9: Each SCL period inside a byte lasts between 4·QDIV and 4·QDIV+4 clock cycles. `sda_oe` never changes in the same cycle as `scl`. While SCL is high, SDA changes only to form a START or a STOP.
- R10: `done` is a single-cycle pulse issued with `busy` already low, once per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Starts a transaction when idle |
| dev_addr | input | 7 | Target 7-bit address |
| reg_addr | input | 8 | Register index inside the target |
| rd_req | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Byte written on a write request |
| rd_len | input | LENW | Number of bytes to read (0 handled as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last transaction ended without acknowledge |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| scl | output | 1 | Serial clock, push-pull |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
A bench-side target model decodes START and STOP from the line, so a design that moved SDA during SCL high would show extra START or STOP counts. A read that skipped the repeated START, or that inserted a STOP before it, would miscount both. The model counts master ACKs and NACKs: an off-by-one on the last byte, or a zero length not treated as one, changes those counts and the number of `rd_valid` strobes. Address and data NACKs check that `err` rises, that the register is left unchanged and that the next request clears `err`. A late acknowledge, raised mid-SCL-high, catches a design that samples the ninth bit only once or that shrinks the wait window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    // bit-level bus commands executed by the phase engine
    typedef enum logic [2:0] {
        BC_START,
        BC_STOP,
        BC_WR,
        BC_RD,
        BC_ACKW
    } bcmd_e;

    // transaction sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_TXB,
        SQ_TXACK,
        SQ_RSTART,
        SQ_RXB,
        SQ_RXACK,
        SQ_STOP
    } seq_e;

    // which byte of the transaction is being sent
    typedef enum logic [1:0] {
        SG_ADDRW,
        SG_REG,
        SG_DATA,
        SG_ADDRR
    } stage_e;

endpackage

// File: rtl/i2cs_qtick.sv
module i2cs_qtick #(
    parameter int QDIV = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(QDIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } qt_t;

    qt_t q, d;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (clr) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(QDIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/i2cs_bitphy.sv
module i2cs_bitphy
    import i2cs_pkg::*;
#(
    parameter int ACK_WAIT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  cmd_go,
    input  bcmd_e cmd,
    input  logic  cmd_bit,
    input  logic  sda_in,
    output logic  accept,
    output logic  cmd_done,
    output logic  rx_bit,
    output logic  scl,
    output logic  sda_oe
);
    localparam int WW = $clog2(ACK_WAIT + 1);

    typedef struct packed {
        logic          busy;
        logic [1:0]    ph;
        bcmd_e         cmd;
        logic          scl;
        logic          oe;
        logic [WW-1:0] wcnt;
        logic          done;
        logic          rbit;
    } phy_t;

    phy_t q, d;

    assign accept = cmd_go && !q.busy;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (cmd_go) begin
                d.busy = 1'b1;
                d.ph   = 2'd0;
                d.cmd  = cmd;
                // quarter 0: SCL keeps its level, SDA set up
                case (cmd)
                    BC_STOP: d.oe = 1'b1;
                    BC_WR:   d.oe = !cmd_bit;
                    default: d.oe = 1'b0;
                endcase
            end
        end else if (tick) begin
            case (q.ph)
                2'd0: begin
                    d.ph  = 2'd1;
                    d.scl = 1'b1;
                end
                2'd1: begin
                    d.ph = 2'd2;
                    d.wcnt = '0;
                    if (q.cmd == BC_START) d.oe = 1'b1;
                    if (q.cmd == BC_STOP)  d.oe = 1'b0;
                end
                2'd2: begin
                    case (q.cmd)
                        BC_ACKW: begin
                            if (!sda_in) begin
                                d.rbit = 1'b0;
                                d.ph   = 2'd3;
                                d.scl  = 1'b0;
                            end else if (q.wcnt == WW'(ACK_WAIT - 1)) begin
                                d.rbit = 1'b1;
                                d.ph   = 2'd3;
                                d.scl  = 1'b0;
                            end else begin
                                d.wcnt = q.wcnt + 1'b1;
                            end
                        end
                        BC_RD: begin
                            d.rbit = sda_in;
                            d.ph   = 2'd3;
                            d.scl  = 1'b0;
                        end
                        BC_STOP: d.ph = 2'd3;
                        default: begin
                            d.ph  = 2'd3;
                            d.scl = 1'b0;
                        end
                    endcase
                end
                default: begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cmd  <= BC_STOP;
            q.scl  <= 1'b1;
            q.rbit <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmd_done = q.done;
    assign rx_bit   = q.rbit;
    assign scl      = q.scl;
    assign sda_oe   = q.oe;
endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
    import i2cs_pkg::*;
#(
    parameter int QDIV     = 63,
    parameter int ACK_WAIT = 8,
    parameter int LENW     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [6:0]      dev_addr,
    input  logic [7:0]      reg_addr,
    input  logic            rd_req,
    input  logic [7:0]      wr_data,
    input  logic [LENW-1:0] rd_len,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [7:0]      rd_data,
    output logic            rd_valid,
    output logic            scl,
    output logic            sda_oe,
    input  logic            sda_in
);
    localparam logic [LENW-1:0] ONE = LENW'(1);

    typedef struct packed {
        seq_e            st;
        stage_e          stg;
        logic            pend;
        logic [7:0]      sh;
        logic [2:0]      bcnt;
        logic [LENW-1:0] left;
        logic [6:0]      dev;
        logic [7:0]      ra;
        logic [7:0]      wd;
        logic            rd;
        logic            err;
        logic            done;
        logic            rv;
        logic [7:0]      rdat;
    } seq_t;

    seq_t  q, d;
    logic  c_go, c_bit, accept, cmd_done, rx_bit, tick;
    bcmd_e c_cmd;

    i2cs_qtick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .tick (tick)
    );

    i2cs_bitphy #(.ACK_WAIT(ACK_WAIT)) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd_go  (c_go),
        .cmd     (c_cmd),
        .cmd_bit (c_bit),
        .sda_in  (sda_in),
        .accept  (accept),
        .cmd_done(cmd_done),
        .rx_bit  (rx_bit),
        .scl     (scl),
        .sda_oe  (sda_oe)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.rv   = 1'b0;
        c_bit  = 1'b1;
        case (q.st)
            SQ_START, SQ_RSTART: c_cmd = BC_START;
            SQ_TXB: begin
                c_cmd = BC_WR;
                c_bit = q.sh[7];
            end
            SQ_TXACK: c_cmd = BC_ACKW;
            SQ_RXB:   c_cmd = BC_RD;
            SQ_RXACK: begin
                c_cmd = BC_WR;
                c_bit = (q.left == ONE);   // release on the final byte
            end
            default:  c_cmd = BC_STOP;
        endcase

        c_go = (q.st != SQ_IDLE) && !q.pend;
        if (c_go) d.pend = 1'b1;

        if (q.st == SQ_IDLE) begin
            if (go) begin
                d.st   = SQ_START;
                d.stg  = SG_ADDRW;
                d.dev  = dev_addr;
                d.ra   = reg_addr;
                d.wd   = wr_data;
                d.rd   = rd_req;
                d.left = (rd_len == '0) ? ONE : rd_len;
                d.sh   = {dev_addr, 1'b0};
                d.err  = 1'b0;
                d.pend = 1'b0;
            end
        end else if (cmd_done) begin
            d.pend = 1'b0;
            case (q.st)
                SQ_START, SQ_RSTART: begin
                    d.st   = SQ_TXB;
                    d.bcnt = '0;
                end
                SQ_TXB: begin
                    d.sh   = {q.sh[6:0], 1'b0};
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == 3'd7) d.st = SQ_TXACK;
                end
                SQ_TXACK: begin
                    if (rx_bit) begin
                        d.err = 1'b1;
                        d.st  = SQ_STOP;
                    end else begin
                        case (q.stg)
                            SG_ADDRW: begin
                                d.sh  = q.ra;
                                d.stg = SG_REG;
                                d.st  = SQ_TXB;
                            end
                            SG_REG: begin
                                if (q.rd) begin
                                    d.sh  = {q.dev, 1'b1};
                                    d.stg = SG_ADDRR;
                                    d.st  = SQ_RSTART;
                                end else begin
                                    d.sh  = q.wd;
                                    d.stg = SG_DATA;
                                    d.st  = SQ_TXB;
                                end
                            end
                            SG_DATA: d.st = SQ_STOP;
                            default: begin
                                d.st   = SQ_RXB;
                                d.bcnt = '0;
                            end
                        endcase
                    end
                end
                SQ_RXB: begin
                    d.sh   = {q.sh[6:0], rx_bit};
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == 3'd7) begin
                        d.st   = SQ_RXACK;
                        d.rdat = {q.sh[6:0], rx_bit};
                        d.rv   = 1'b1;
                    end
                end
                SQ_RXACK: begin
                    if (q.left == ONE) begin
                        d.st = SQ_STOP;
                    end else begin
                        d.left = q.left - ONE;
                        d.st   = SQ_RXB;
                        d.bcnt = '0;
                    end
                end
                default: begin
                    d.st   = SQ_IDLE;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= SQ_IDLE;
            q.stg <= SG_ADDRW;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != SQ_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign rd_data  = q.rdat;
    assign rd_valid = q.rv;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic go,
    input logic busy,
    input logic done,
    input logic err,
    input logic rd_valid,
    input logic scl,
    input logic sda_oe
);
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_oe));

    assert_sda_scl_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $stable(scl));

    assert_rvalid_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(err));
endmodule

bind i2c_regseq i2cs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rd_valid(rd_valid),
    .scl     (scl),
    .sda_oe  (sda_oe)
);

// File: tb/sim_i2c_regseq.sv
module sim_i2c_regseq;
    localparam int CLK_P  = 10;
    localparam int QD     = 8;
    localparam int AW     = 6;
    localparam int LATE_T = 2 * QD * CLK_P + 3;
    localparam logic [6:0] SLV = 7'h68;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0;
    logic       rd_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_len = '0;
    logic       busy, done, err, rd_valid, scl_w, oe_w;
    logic [7:0] rd_data;
    logic       line;

    // target model state
    logic       pull = 1'b0, late_pull = 1'b0;
    logic       s_prev = 1'b1, o_prev = 1'b0;
    logic       active = 1'b0, first = 1'b0, tmode = 1'b0, to_tx = 1'b0, lat_arm = 1'b0, ack = 1'b0;
    int         p = 0, wcount = 0;
    logic [7:0] rx = '0, tx = '0, ptr = '0, ab_last = '0, ab_prev = '0;
    logic [7:0] mem [256];
    int         starts = 0, stops = 0, macks = 0, mnacks = 0;
    logic       nack_data = 1'b0, late_mode = 1'b0;

    int         vecs = 0, errs = 0;
    logic [7:0] rxb [16];
    int         nrx = 0;

    always #(CLK_P/2) clk = ~clk;

    assign line = !(oe_w | pull | late_pull);

    i2c_regseq #(.QDIV(QD), .ACK_WAIT(AW), .LENW(4)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr), .reg_addr(reg_addr),
        .rd_req(rd_req), .wr_data(wr_data), .rd_len(rd_len), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .rd_valid(rd_valid), .scl(scl_w), .sda_oe(oe_w),
        .sda_in(line)
    );

    // bus target model: one process for every line event
    always @(scl_w or oe_w) begin
        if (scl_w !== s_prev) begin
            if (scl_w) begin
                if (active) begin
                    if (p < 8) begin
                        rx = {rx[6:0], line};
                        p++;
                    end else begin
                        if (tmode) begin
                            if (!line) begin macks++; tx = mem[ptr]; ptr++; end
                            else begin mnacks++; active = 1'b0; end
                        end else if (to_tx) begin
                            tmode = 1'b1; to_tx = 1'b0; tx = mem[ptr]; ptr++;
                        end
                        if (lat_arm) begin
                            lat_arm = 1'b0;
                            fork begin #(LATE_T); late_pull = 1'b1; end join_none
                        end
                        p = 0;
                    end
                end
            end else begin
                late_pull = 1'b0;
                if (!active) pull = 1'b0;
                else if (p == 8) begin
                    if (tmode) pull = 1'b0;
                    else begin
                        if (first) begin
                            first = 1'b0;
                            ab_prev = ab_last; ab_last = rx;
                            if (rx[7:1] == SLV) begin ack = 1'b1; to_tx = rx[0]; wcount = 0; end
                            else begin ack = 1'b0; active = 1'b0; end
                        end else begin
                            if (wcount == 0) begin ptr = rx; ack = 1'b1; end
                            else if (nack_data) begin ack = 1'b0; active = 1'b0; end
                            else begin mem[ptr] = rx; ptr++; ack = 1'b1; end
                            wcount++;
                        end
                        if (ack && late_mode) begin pull = 1'b0; lat_arm = 1'b1; end
                        else pull = ack;
                    end
                end else pull = tmode ? ~tx[7-p] : 1'b0;
            end
        end else if (oe_w !== o_prev && scl_w) begin
            if (oe_w) begin
                starts++; active = 1'b1; p = 0; first = 1'b1; tmode = 1'b0; to_tx = 1'b0;
            end else begin
                stops++; active = 1'b0; tmode = 1'b0; pull = 1'b0;
            end
        end
        s_prev = scl_w;
        o_prev = oe_w;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [6:0] a, input logic [7:0] r, input logic rd,
                       input logic [7:0] wd, input logic [3:0] n);
        nrx = 0;
        @(negedge clk);
        dev_addr = a; reg_addr = r; rd_req = rd; wr_data = wd; rd_len = n; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                if (nrx < 16) rxb[nrx] = rd_data;
                nrx++;
            end
            if (done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] fval(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic t_reset();
        chk("R1 scl", 32'(scl_w), 1);
        chk("R1 sda_oe", 32'(oe_w), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
    endtask

    task automatic t_write_fill();
        for (int i = 0; i < 4; i++) begin
            int s0 = starts, p0 = stops;
            run(SLV, 8'(8'h20 + i), 1'b0, fval(i), 4'd0);
            chk("R3 err", 32'(err), 0);
            chk("R3 reg value", 32'(mem[8'h20 + i]), 32'(fval(i)));
            chk("R3 starts", 32'(starts - s0), 1);
            chk("R3 stops", 32'(stops - p0), 1);
            chk("R2 write address byte", 32'(ab_last), 32'h0D0);
            chk("R1 idle after", 32'({scl_w, oe_w, busy}), 32'b100);
        end
    endtask

    task automatic t_read4();
        int s0 = starts, p0 = stops, a0 = macks, n0 = mnacks;
        run(SLV, 8'h20, 1'b1, 8'h00, 4'd4);
        chk("R5 byte count", 32'(nrx), 4);
        for (int i = 0; i < 4; i++) chk("R5 byte value", 32'(rxb[i]), 32'(fval(i)));
        chk("R4 starts", 32'(starts - s0), 2);
        chk("R4 stops", 32'(stops - p0), 1);
        chk("R2 pointer address byte", 32'(ab_prev), 32'h0D0);
        chk("R2 read address byte", 32'(ab_last), 32'h0D1);
        chk("R6 master acks", 32'(macks - a0), 3);
        chk("R6 master nack", 32'(mnacks - n0), 1);
        chk("R5 err", 32'(err), 0);
    endtask

    task automatic t_read_len0();
        int a0 = macks, n0 = mnacks;
        run(SLV, 8'h22, 1'b1, 8'h00, 4'd0);
        chk("R5 zero length count", 32'(nrx), 1);
        chk("R5 zero length value", 32'(rxb[0]), 32'(fval(2)));
        chk("R6 single byte acks", 32'(macks - a0), 0);
        chk("R6 single byte nack", 32'(mnacks - n0), 1);
    endtask

    task automatic t_addr_nack();
        int s0 = starts, p0 = stops;
        run(7'h33, 8'h20, 1'b0, 8'hEE, 4'd0);
        chk("R7 address nack err", 32'(err), 1);
        chk("R7 address nack stop", 32'(stops - p0), 1);
        chk("R7 address nack starts", 32'(starts - s0), 1);
        chk("R7 register untouched", 32'(mem[8'h20]), 32'(fval(0)));
        repeat (20) @(negedge clk);
        chk("R7 err held while idle", 32'(err), 1);
        run(7'h33, 8'h21, 1'b1, 8'h00, 4'd3);
        chk("R7 read nack no bytes", 32'(nrx), 0);
        chk("R7 read nack err", 32'(err), 1);
        run(SLV, 8'h25, 1'b0, 8'h3C, 4'd0);
        chk("R7 err cleared by go", 32'(err), 0);
        chk("R7 recovered write", 32'(mem[8'h25]), 32'h3C);
    endtask

    task automatic t_data_nack();
        int p0 = stops;
        nack_data = 1'b1;
        run(SLV, 8'h21, 1'b0, 8'h99, 4'd0);
        nack_data = 1'b0;
        chk("R7 data nack err", 32'(err), 1);
        chk("R7 data nack stop", 32'(stops - p0), 1);
        chk("R7 data nack register", 32'(mem[8'h21]), 32'(fval(1)));
        chk("R7 bus idle", 32'({scl_w, oe_w}), 32'b10);
    endtask

    task automatic t_late_ack();
        late_mode = 1'b1;
        run(SLV, 8'h30, 1'b0, 8'hA7, 4'd0);
        late_mode = 1'b0;
        chk("R8 late ack err", 32'(err), 0);
        chk("R8 late ack register", 32'(mem[8'h30]), 32'hA7);
    endtask

    task automatic t_period();
        time t1, t2;
        int cyc;
        @(negedge clk);
        dev_addr = SLV; reg_addr = 8'h31; rd_req = 1'b0; wr_data = 8'h11; rd_len = 0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(posedge scl_w); t1 = $time;
        @(posedge scl_w); t2 = $time;
        cyc = int'((t2 - t1) / CLK_P);
        chk("R9 period lower bound", 32'(cyc >= 4 * QD), 1);
        chk("R9 period upper bound", 32'(cyc <= 4 * QD + 4), 1);
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 done then idle", 32'({busy, done}), 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs + 1, errs + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_fill();
        t_read4();
        t_read_len0();
        t_addr_nack();
        t_data_nack();
        t_late_ack();
        t_period();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule